// File: doc/BRIEF.md
# Bidirectional Audio Sample FIFO with Threshold DMA Requests

This block sits between a register data port and an audio serializer and holds sample words in two independent queues, one for playback and one for capture. Software or a DMA engine writes playback words to a single data address and reads capture words from the same address. The serializer pulls playback words and pushes capture words one at a time. Samples move on the serializer side only while that direction and the global enable are both on.

Each direction asks for DMA service by comparing its queue against a programmable 5-bit threshold. Playback asks while enough free space remains, and capture asks while enough words are waiting. Each queue can be emptied by a soft-reset bit that clears itself. Sticky error flags record a playback pull from an empty queue and a capture push into a full queue, and a masked interrupt output is formed from them. A frame counter counts serializer frames while either direction runs.

Top module: `audio_fifo_dma`

## Requirements
- R1: After reset both queues are empty, status (0x10) reads 0, the queue control register (0x0C) reads 0x00101000 (both thresholds 16, DMA and reset bits 0), the run register (0x04), interrupt flags and frame counter read 0, and irq and both DMA requests are low.
- R2: A write to the data address 0x1C appends the write data to the playback queue, which holds 32 words; a write while it holds 32 words is dropped.
- R3: Run register bit 0 (playback) and bit 2 (global) must both be 1 for txPull to take a word. The oldest word is shown on txWord in the pull cycle and leaves the queue at that clock edge. When either bit is 0, txPull has no effect.
- R4: With run bits 1 (capture) and 2 both set, rxPush stores rxWord in the capture queue, otherwise rxPush is ignored; a read of 0x1C returns the oldest capture word in the same cycle and removes it, and returns 0 with no change when the queue is empty.
- R5: Status register 0x10 holds the playback level in bits 5:0 and the capture level in bits 13:8, readable in the cycle regRd is high.
- R6: txDmaReq is high exactly when control bit 4 is 1 and the playback free space (32 minus level) is at least the threshold in control bits 12:8.
- R7: rxDmaReq is high exactly when control bit 5 is 1 and the capture level is at least the threshold in control bits 20:16.
- R8: Writing 1 to control bit 0 (playback) or bit 1 (capture) empties that queue at the write edge; the bit reads 1 in the next cycle and 0 after that, while the other control fields take the written value.
- R9: Interrupt flags at 0x18: bit 0 is set by a running pull on an empty playback queue, bit 1 by a running push into a full capture queue (the word is dropped); both stay set until a 1 is written to that bit.
- R10: irq is high exactly when a flag at 0x18 is set whose enable bit at 0x14 (bit 0 or bit 1) is 1.
- R11: The frame counter at 0x20 rises by one on each frameTick cycle while playback or capture is running, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a read of 0x1C pops) |
| regAddr | input | ADDR_W | Register byte offset |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, same cycle |
| txPull | input | 1 | Serializer takes one playback word |
| txWord | output | DATA_W | Oldest playback word (0 when empty) |
| rxPush | input | 1 | Serializer delivers one capture word |
| rxWord | input | DATA_W | Capture word from the serializer |
| frameTick | input | 1 | One-cycle pulse per completed frame |
| txDmaReq | output | 1 | Playback DMA request |
| rxDmaReq | output | 1 | Capture DMA request |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions take for granted that regWr and regRd are never high in the same cycle, and that the reset bits and data traffic are not driven to the same queue in one cycle. The stimulus keeps within this because every register access task drives one strobe for exactly one cycle and returns before the next access starts. Serializer strobes likewise last a single cycle and are driven on the falling edge.

// File: rtl/afd_pkg.sv
package afd_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } afdStrobes_t;

  localparam int OFS_RUN   = 'h04;
  localparam int OFS_QCTL  = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_IEN   = 'h14;
  localparam int OFS_IFLG  = 'h18;
  localparam int OFS_DATA  = 'h1C;
  localparam int OFS_FRAME = 'h20;

  localparam int TX_THR_LSB = 8;
  localparam int RX_THR_LSB = 16;
  localparam int RX_LVL_LSB = 8;
endpackage

// File: rtl/afd_ring.sv
module afd_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout = mem[rdPtr];

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (level != LVL_W'(DEPTH)) || pop);
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> level != '0);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> level == '0);
endmodule

// File: rtl/afd_datapath.sv
module afd_datapath import afd_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  afdStrobes_t       strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  // index 0 = playback, index 1 = capture
  logic              qPush [2];
  logic              qPop  [2];
  logic              qClr  [2];
  logic [DATA_W-1:0] qIn   [2];
  logic [DATA_W-1:0] qOut  [2];
  logic [LVL_W-1:0]  qLvl  [2];

  assign qPush[0] = strb.txPush;
  assign qPop[0]  = strb.txPop;
  assign qClr[0]  = strb.txClr;
  assign qIn[0]   = regWdata;
  assign qPush[1] = strb.rxPush;
  assign qPop[1]  = strb.rxPop;
  assign qClr[1]  = strb.rxClr;
  assign qIn[1]   = rxWord;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    afd_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_ring (
      .clk(clk), .rstN(rstN),
      .push(qPush[d]), .pop(qPop[d]), .clr(qClr[d]),
      .din(qIn[d]), .dout(qOut[d]), .level(qLvl[d])
    );
  end

  assign txHead  = qOut[0];
  assign rxHead  = qOut[1];
  assign txLevel = qLvl[0];
  assign rxLevel = qLvl[1];
endmodule

// File: rtl/afd_ctrl.sv
module afd_ctrl import afd_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 32,
  parameter int ADDR_W    = 6,
  parameter int THR_W     = 5,
  parameter int THR_RESET = 16,
  parameter int FRM_W     = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPull,
  input  logic              rxPush,
  input  logic              frameTick,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  output afdStrobes_t       strb,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              irq
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [2:0]       runReg;
  logic             txDmaEn, rxDmaEn;
  logic [THR_W-1:0] txThr, rxThr;
  logic [1:0]       clrBits;
  logic [1:0]       intEn, intFlag;
  logic [FRM_W-1:0] frameCnt;

  logic txRun, rxRun;
  assign txRun = runReg[0] && runReg[2];
  assign rxRun = runReg[1] && runReg[2];

  logic wrRun, wrQctl, wrIen, wrIflg, wrData, rdData;
  assign wrRun  = regWr && (regAddr == ADDR_W'(OFS_RUN));
  assign wrQctl = regWr && (regAddr == ADDR_W'(OFS_QCTL));
  assign wrIen  = regWr && (regAddr == ADDR_W'(OFS_IEN));
  assign wrIflg = regWr && (regAddr == ADDR_W'(OFS_IFLG));
  assign wrData = regWr && (regAddr == ADDR_W'(OFS_DATA));
  assign rdData = regRd && (regAddr == ADDR_W'(OFS_DATA));

  logic txEmpty, rxEmpty, txFull, rxFull;
  assign txEmpty = (txLevel == '0);
  assign rxEmpty = (rxLevel == '0);
  assign txFull  = (txLevel == FULL);
  assign rxFull  = (rxLevel == FULL);

  always_comb begin
    strb.txPush = wrData && !txFull;
    strb.txPop  = txPull && txRun && !txEmpty;
    strb.rxPush = rxPush && rxRun && !rxFull;
    strb.rxPop  = rdData && !rxEmpty;
    strb.txClr  = wrQctl && regWdata[0];
    strb.rxClr  = wrQctl && regWdata[1];
  end

  logic underrunEv, overrunEv;
  assign underrunEv = txPull && txRun && txEmpty;
  assign overrunEv  = rxPush && rxRun && rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg   <= '0;
      txDmaEn  <= 1'b0;
      rxDmaEn  <= 1'b0;
      txThr    <= THR_W'(THR_RESET);
      rxThr    <= THR_W'(THR_RESET);
      clrBits  <= '0;
      intEn    <= '0;
      intFlag  <= '0;
      frameCnt <= '0;
    end else begin
      if (wrRun) runReg <= regWdata[2:0];
      if (wrQctl) begin
        txDmaEn <= regWdata[4];
        rxDmaEn <= regWdata[5];
        txThr   <= regWdata[TX_THR_LSB +: THR_W];
        rxThr   <= regWdata[RX_THR_LSB +: THR_W];
        clrBits <= regWdata[1:0];
      end else begin
        clrBits <= '0;
      end
      if (wrIen) intEn <= regWdata[1:0];
      intFlag <= (intFlag & ~(wrIflg ? regWdata[1:0] : 2'b00))
               | {overrunEv, underrunEv};
      if (frameTick && (txRun || rxRun)) frameCnt <= frameCnt + 1'b1;
    end
  end

  logic [LVL_W-1:0] txFree;
  assign txFree   = FULL - txLevel;
  assign txDmaReq = txDmaEn && (32'(txFree) >= 32'(txThr));
  assign rxDmaReq = rxDmaEn && (32'(rxLevel) >= 32'(rxThr));
  assign irq      = |(intFlag & intEn);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(OFS_RUN):  regRdata[2:0] = runReg;
      ADDR_W'(OFS_QCTL): begin
        regRdata[1:0] = clrBits;
        regRdata[4]   = txDmaEn;
        regRdata[5]   = rxDmaEn;
        regRdata[TX_THR_LSB +: THR_W] = txThr;
        regRdata[RX_THR_LSB +: THR_W] = rxThr;
      end
      ADDR_W'(OFS_STAT): begin
        regRdata[LVL_W-1:0] = txLevel;
        regRdata[RX_LVL_LSB +: LVL_W] = rxLevel;
      end
      ADDR_W'(OFS_IEN):   regRdata[1:0] = intEn;
      ADDR_W'(OFS_IFLG):  regRdata[1:0] = intFlag;
      ADDR_W'(OFS_DATA):  regRdata = rxEmpty ? '0 : rxHead;
      ADDR_W'(OFS_FRAME): regRdata[FRM_W-1:0] = frameCnt;
      default:            regRdata = '0;
    endcase
  end

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    intFlag[0] && !(wrIflg && regWdata[0]) |=> intFlag[0]);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    intFlag[1] && !(wrIflg && regWdata[1]) |=> intFlag[1]);
  a_r8_clear_selfclears: assert property (@(posedge clk) disable iff (!rstN)
    (clrBits != 2'b00) && !wrQctl |=> clrBits == 2'b00);
  a_r11_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    (frameCnt != $past(frameCnt)) |-> (frameCnt == $past(frameCnt) + 1'b1));
  a_r3_pop_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel < $past(txLevel)) && !$past(strb.txClr) |-> $past(txRun));
  a_r4_push_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel > $past(rxLevel)) |-> $past(rxRun));
endmodule

// File: rtl/audio_fifo_dma.sv
module audio_fifo_dma import afd_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 32,
  parameter int ADDR_W    = 6,
  parameter int THR_W     = 5,
  parameter int THR_RESET = 16,
  parameter int FRM_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPull,
  output logic [DATA_W-1:0] txWord,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              frameTick,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              irq
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  afdStrobes_t       strb;
  logic [DATA_W-1:0] txHead, rxHead;
  logic [LVL_W-1:0]  txLevel, rxLevel;

  afd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .THR_W(THR_W),
             .THR_RESET(THR_RESET), .FRM_W(FRM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txPull(txPull), .rxPush(rxPush),
    .frameTick(frameTick), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .strb(strb), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irq(irq)
  );

  afd_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .rxWord(rxWord),
    .txHead(txHead), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel)
  );

  assign txWord = (txLevel == '0) ? '0 : txHead;
endmodule

// File: tb/audio_fifo_dma_test.sv
module audio_fifo_dma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        txPull = 1'b0, rxPush = 1'b0, frameTick = 1'b0;
  logic [31:0] txWord, rxWord = '0;
  logic        txDmaReq, rxDmaReq, irq;

  int checks = 0, failures = 0;
  bit done = 0;
  bit txRunM = 0, rxRunM = 0;
  logic [31:0] txQ[$], rxQ[$];
  logic [31:0] rd;

  always #10 clk = ~clk;

  audio_fifo_dma uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(int a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 6'(a); regWdata = d;
    if (a == 'h04) begin txRunM = d[0] & d[2]; rxRunM = d[1] & d[2]; end
    if (a == 'h1C && txQ.size() < 32) txQ.push_back(d);
    if (a == 'h0C && d[0]) txQ.delete();
    if (a == 'h0C && d[1]) rxQ.delete();
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic regRead(int a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = 6'(a);
    #1 d = regRdata;
    @(posedge clk); #1 regRd = 1'b0;
  endtask

  task automatic readData(string tag);
    logic [31:0] v, e;
    regRead('h1C, v);
    e = (rxQ.size() > 0) ? rxQ.pop_front() : 32'h0;
    chk(tag, v, e);
  endtask

  task automatic pull();
    @(negedge clk); txPull = 1'b1;
    @(posedge clk); #1 txPull = 1'b0;
  endtask

  task automatic pushRx(logic [31:0] w);
    @(negedge clk); rxPush = 1'b1; rxWord = w;
    if (rxRunM && rxQ.size() < 32) rxQ.push_back(w);
    @(posedge clk); #1 rxPush = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frameTick = 1'b1;
    @(posedge clk); #1 frameTick = 1'b0;
  endtask

  // monitor: compares every accepted pull with the scoreboard head (R3)
  always @(negedge clk) begin
    #2;
    if (txPull && txRunM && txQ.size() > 0) chk("R3 txWord order", txWord, txQ.pop_front());
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    regRead('h10, rd); chk("R1 status", rd, 0);
    regRead('h0C, rd); chk("R1 qctl", rd, 32'h00101000);
    regRead('h04, rd); chk("R1 run", rd, 0);
    regRead('h18, rd); chk("R1 flags", rd, 0);
    regRead('h20, rd); chk("R1 frame", rd, 0);
    chk("R1 outs", {29'b0, irq, txDmaReq, rxDmaReq}, 0);
    // R2/R5 playback writes
    for (int i = 0; i < 3; i++) regWrite('h1C, 32'hA000 + i);
    regRead('h10, rd); chk("R5 tx level", rd, 3);
    // R3 gated: playback bit without global
    regWrite('h04, 1);
    pull();
    regRead('h10, rd); chk("R3 gated pull", rd, 3);
    regRead('h18, rd); chk("R3 gated no flag", rd, 0);
    regWrite('h04, 7);
    for (int i = 0; i < 3; i++) pull();
    regRead('h10, rd); chk("R3 drained", rd, 0);
    // R9/R10 underrun
    pull();
    regRead('h18, rd); chk("R9 underrun", rd, 1);
    chk("R10 masked", irq, 0);
    regWrite('h14, 1);
    chk("R10 enabled", irq, 1);
    regWrite('h18, 1);
    regRead('h18, rd); chk("R9 w1c", rd, 0);
    chk("R10 cleared", irq, 0);
    // R2 full queue drops extra word
    for (int i = 0; i < 33; i++) regWrite('h1C, 32'hB000 + i);
    regRead('h10, rd); chk("R2 full level", rd, 32);
    for (int i = 0; i < 32; i++) pull();
    chk("R2 extra dropped", 32'(txQ.size()), 0);
    regRead('h10, rd); chk("R2 empty", rd, 0);
    // R6 tx DMA threshold 16
    regWrite('h0C, 32'h00001010);
    chk("R6 empty req", txDmaReq, 1);
    for (int i = 0; i < 17; i++) regWrite('h1C, 32'hC000 + i);
    chk("R6 free 15", txDmaReq, 0);
    pull();
    chk("R6 free 16", txDmaReq, 1);
    // R8 playback soft reset
    regWrite('h0C, 32'h00001011);
    regRead('h0C, rd); chk("R8 bit visible", rd, 32'h00001011);
    regRead('h0C, rd); chk("R8 bit cleared", rd, 32'h00001010);
    regRead('h10, rd); chk("R8 tx emptied", rd, 0);
    // R4/R7 capture with threshold 2
    regWrite('h0C, 32'h00020020);
    pushRx(32'hD001);
    chk("R7 level 1", rxDmaReq, 0);
    pushRx(32'hD002);
    chk("R7 level 2", rxDmaReq, 1);
    regRead('h10, rd); chk("R5 rx level", rd, 32'h200);
    readData("R4 read 1");
    readData("R4 read 2");
    readData("R4 read empty");
    regWrite('h04, 5);
    pushRx(32'hDEAD);
    regRead('h10, rd); chk("R4 gated push", rd, 0);
    // R9 overrun
    regWrite('h04, 7);
    for (int i = 0; i < 33; i++) pushRx(32'hE000 + i);
    regRead('h18, rd); chk("R9 overrun", rd, 2);
    regRead('h10, rd); chk("R9 rx full", rd, 32'h2000);
    regWrite('h14, 2);
    chk("R10 overrun irq", irq, 1);
    readData("R9 oldest kept");
    // R8 capture soft reset
    regWrite('h0C, 32'h00020022);
    regRead('h10, rd); chk("R8 rx emptied", rd, 0);
    // R11 frame counter
    tick(); tick();
    regRead('h20, rd); chk("R11 running", rd, 2);
    regWrite('h04, 0);
    tick();
    regRead('h20, rd); chk("R11 idle", rd, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule